// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block decides when a small processor core enters an interrupt service routine and how it returns from one. It looks at requests only when the core signals that an instruction has retired, and it handles one request at a time. There are three kinds of request. A software interrupt comes with its own 8-bit vector. A non-maskable request always uses vector 2 and is caught on its rising edge. A level-sensitive maskable request is accepted only while the interrupt-enable flag is set, and it gets its vector from an external interrupt controller through a one-cycle acknowledge.

On entry, the sequencer saves the return program counter and the enable flag together on an internal stack, then clears the flag. It then reads the routine address from an internal vector table, indexed by the chosen vector, and loads it into the PC. A return strobe pops the stack, reloads the PC and restores the flag. The core fills the vector table through a simple write port.

States are IDLE, ACK, CAPT, PUSH, VEC and POP. The transitions are:
- IDLE→PUSH when a software or non-maskable request is taken.
- IDLE→POP on a return.
- IDLE→ACK when the maskable request is taken.
- ACK→CAPT and CAPT→PUSH unconditionally.
- PUSH→VEC, VEC→IDLE and POP→IDLE unconditionally.

Top module: `irq_seq`

## Requirements
- R1: After reset, pc_load, int_ack, ie, busy, stk_ovf and stk_unf are all 0.
- R2: Requests are taken only in a cycle where insn_done is 1 and busy is 0. At any other time they cause no PC load and busy stays 0.
- R3: A software or non-maskable entry saves the pc_in value present at the boundary. pc_load is 1 for exactly one cycle, two cycles after the boundary edge, with pc_out equal to the table entry at the chosen vector.
- R4: The non-maskable request uses vector 2 whatever the value of ie. Each rising edge of nmi_req is serviced exactly once, even if the line is then held high.
- R5: While ie is 0, int_req is ignored: no int_ack and no PC load follow.
- R6: A taken maskable request drives int_ack high for exactly one cycle, starting one cycle after the boundary edge. int_vec is sampled in the cycle after int_ack, and pc_load follows four cycles after the boundary edge.
- R7: A software interrupt uses swi_vec (0 to 255) as its vector.
- R8: When several requests are present at the same boundary, the order of precedence is software interrupt, then return, then non-maskable, then maskable. Requests that lose stay pending for a later boundary (the maskable one only while it is still asserted).
- R9: Entry clears ie. A return restores ie to the value it had at entry.
- R10: On a return, pc_load is 1 one cycle after the boundary edge, with pc_out equal to the most recently saved PC (last in, first out).
- R11: A push onto a full stack sets stk_ovf, which then stays set. The push is dropped, but the vector is still loaded.
- R12: A return with an empty stack sets stk_unf, which then stays set, and produces no pc_load.
- R13: ie_set sets ie and ie_clr clears it, taking effect on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| insn_done | input | 1 | Instruction-boundary strobe |
| pc_in | input | PC_W | Address of the next instruction |
| swi_req | input | 1 | Software interrupt request |
| swi_vec | input | VEC_W | Software interrupt vector |
| iret_req | input | 1 | Return-from-interrupt strobe |
| nmi_req | input | 1 | Non-maskable request, edge-detected |
| int_req | input | 1 | Maskable request, level-sensitive |
| int_ack | output | 1 | Acknowledge to the interrupt controller |
| int_vec | input | VEC_W | Vector from the controller, valid in the cycle after int_ack |
| ie_set | input | 1 | Set the enable flag |
| ie_clr | input | 1 | Clear the enable flag |
| tbl_we | input | 1 | Vector table write enable |
| tbl_idx | input | VEC_W | Vector table write index |
| tbl_data | input | PC_W | Vector table write data |
| pc_load | output | 1 | Load pc_out into the PC |
| pc_out | output | PC_W | New PC value |
| ie | output | 1 | Interrupt-enable flag |
| busy | output | 1 | Sequence in progress |
| stk_ovf | output | 1 | Sticky stack overflow |
| stk_unf | output | 1 | Sticky stack underflow |

## Verification
Inputs change on the falling edge and outputs are sampled on the falling edge. Each result is therefore checked at a fixed falling edge counted from the boundary edge:
- Software and non-maskable entries: pc_load at the second falling edge.
- Returns: pc_load at the first falling edge, and the restored ie at the second.
- Maskable entries: int_ack at the first falling edge, and pc_load at the fourth.

The bench also checks the cycles where nothing should happen. These are the edge before an expected load, the edge after int_ack, and the edges following ignored or masked requests.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_CAPT,
        ST_PUSH,
        ST_VEC,
        ST_POP
    } seq_state_e;
endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic take,
    output logic pend
);
    logic req_d;
    logic rise;

    assign rise = req & ~req_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_d <= 1'b0;
            pend  <= 1'b0;
        end else begin
            req_d <= req;
            pend  <= (pend & ~take) | rise;
        end
    end

    AST_NMI_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |=> pend); // R4
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
    parameter int VEC_W = 8,
    parameter int PC_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [VEC_W-1:0] widx,
    input  logic [PC_W-1:0]  wdata,
    input  logic [VEC_W-1:0] ridx,
    output logic [PC_W-1:0]  rdata
);
    localparam int DEPTH = 1 << VEC_W;

    logic [PC_W-1:0] entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry[g] <= '0;
            end else if (we && (widx == VEC_W'(g))) begin
                entry[g] <= wdata;
            end
        end
    end

    assign rdata = entry[ridx];
endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
    parameter int W     = 17,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         ovf,
    output logic         unf
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt;
    logic          full;
    logic [IW-1:0] top_idx;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign top_idx = IW'(cnt - CW'(1));
    assign dout    = empty ? '0 : mem[top_idx];

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[IW'(cnt)] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else if (push) begin
            if (full) ovf <= 1'b1;
            else      cnt <= cnt + CW'(1);
        end else if (pop) begin
            if (empty) unf <= 1'b1;
            else       cnt <= cnt - CW'(1);
        end
    end

    AST_NO_PUSH_WITH_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop)); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R11
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf); // R11
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unf |=> unf); // R12
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int VEC_W     = 8,
    parameter int STK_DEPTH = 8,
    parameter int NMI_VEC   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_done,
    input  logic [PC_W-1:0]  pc_in,
    input  logic             swi_req,
    input  logic [VEC_W-1:0] swi_vec,
    input  logic             iret_req,
    input  logic             nmi_req,
    input  logic             int_req,
    output logic             int_ack,
    input  logic [VEC_W-1:0] int_vec,
    input  logic             ie_set,
    input  logic             ie_clr,
    input  logic             tbl_we,
    input  logic [VEC_W-1:0] tbl_idx,
    input  logic [PC_W-1:0]  tbl_data,
    output logic             pc_load,
    output logic [PC_W-1:0]  pc_out,
    output logic             ie,
    output logic             busy,
    output logic             stk_ovf,
    output logic             stk_unf
);
    localparam int SW = PC_W + 1;

    seq_state_e       state_q, state_d;
    logic [VEC_W-1:0] vec_q;
    logic [PC_W-1:0]  pc_q;
    logic             ie_q;
    logic             nmi_pend;
    logic             take_swi, take_ret, take_nmi, take_int;
    logic             stk_push, stk_pop, stk_empty;
    logic [SW-1:0]    stk_top;
    logic [PC_W-1:0]  tbl_rd;

    irq_nmi_edge u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (nmi_req),
        .take  (take_nmi),
        .pend  (nmi_pend)
    );

    irq_vec_table #(.VEC_W(VEC_W), .PC_W(PC_W)) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .widx  (tbl_idx),
        .wdata (tbl_data),
        .ridx  (vec_q),
        .rdata (tbl_rd)
    );

    irq_ret_stack #(.W(SW), .DEPTH(STK_DEPTH)) u_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (stk_push),
        .pop   (stk_pop),
        .din   ({ie_q, pc_q}),
        .dout  (stk_top),
        .empty (stk_empty),
        .ovf   (stk_ovf),
        .unf   (stk_unf)
    );

    // Request selection at a boundary, precedence: software, return, NMI, maskable
    always_comb begin
        take_swi = 1'b0;
        take_ret = 1'b0;
        take_nmi = 1'b0;
        take_int = 1'b0;
        if (state_q == ST_IDLE && insn_done) begin
            if (swi_req)             take_swi = 1'b1;
            else if (iret_req)       take_ret = 1'b1;
            else if (nmi_pend)       take_nmi = 1'b1;
            else if (int_req && ie_q) take_int = 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_swi || take_nmi) state_d = ST_PUSH;
                else if (take_ret)        state_d = ST_POP;
                else if (take_int)        state_d = ST_ACK;
            end
            ST_ACK:  state_d = ST_CAPT;
            ST_CAPT: state_d = ST_PUSH;
            ST_PUSH: state_d = ST_VEC;
            ST_VEC:  state_d = ST_IDLE;
            ST_POP:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        int_ack  = 1'b0;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        pc_load  = 1'b0;
        pc_out   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACK:  int_ack = 1'b1;
            ST_CAPT: ;
            ST_PUSH: stk_push = 1'b1;
            ST_VEC: begin
                pc_load = 1'b1;
                pc_out  = tbl_rd;
            end
            ST_POP: begin
                stk_pop = 1'b1;
                pc_load = ~stk_empty;
                pc_out  = stk_top[PC_W-1:0];
            end
            default: ;
        endcase
    end

    // Saved vector, return address and enable flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
            pc_q  <= '0;
            ie_q  <= 1'b0;
        end else begin
            if (take_swi)                        vec_q <= swi_vec;
            else if (take_nmi)                   vec_q <= VEC_W'(NMI_VEC);
            else if (state_q == ST_CAPT)         vec_q <= int_vec;

            if (take_swi || take_nmi || take_int) pc_q <= pc_in;

            if (state_q == ST_PUSH)                     ie_q <= 1'b0;
            else if (state_q == ST_POP && !stk_empty)   ie_q <= stk_top[PC_W];
            else if (ie_set)                            ie_q <= 1'b1;
            else if (ie_clr)                            ie_q <= 1'b0;
        end
    end

    assign ie   = ie_q;
    assign busy = (state_q != ST_IDLE);

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> !int_ack); // R6
    AST_ACK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> ($past(int_req) && $past(ie_q))); // R5
    AST_IE_CLEARED_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push |=> !ie); // R9
    AST_VEC_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VEC) |-> ($past(state_q) == ST_PUSH)); // R3
    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load); // R3
endmodule

// File: tb/irq_seq_tb_top.sv
module irq_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    // kind[25:24]: 0 software, 1 non-maskable, 2 maskable; vec[23:16]; pc[15:0]
    localparam logic [25:0] VTAB [NV] = '{
        {2'd0, 8'h00, 16'h0100},
        {2'd0, 8'hFF, 16'h0204},
        {2'd1, 8'h00, 16'h1234},
        {2'd2, 8'h40, 16'hBEEF},
        {2'd2, 8'hFE, 16'h0002},
        {2'd0, 8'h02, 16'hFFFE}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_done = 1'b0;
    logic [15:0] pc_in = '0;
    logic        swi_req = 1'b0;
    logic [7:0]  swi_vec = '0;
    logic        iret_req = 1'b0;
    logic        nmi_req = 1'b0;
    logic        int_req = 1'b0;
    logic        int_ack;
    logic [7:0]  int_vec = '0;
    logic        ie_set = 1'b0;
    logic        ie_clr = 1'b0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_idx = '0;
    logic [15:0] tbl_data = '0;
    logic        pc_load;
    logic [15:0] pc_out;
    logic        ie, busy, stk_ovf, stk_unf;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_seq dut_i (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .pc_in(pc_in),
        .swi_req(swi_req), .swi_vec(swi_vec), .iret_req(iret_req),
        .nmi_req(nmi_req), .int_req(int_req), .int_ack(int_ack),
        .int_vec(int_vec), .ie_set(ie_set), .ie_clr(ie_clr),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_data(tbl_data),
        .pc_load(pc_load), .pc_out(pc_out), .ie(ie), .busy(busy),
        .stk_ovf(stk_ovf), .stk_unf(stk_unf)
    );

    function automatic logic [15:0] tgt(input logic [7:0] v);
        return {v ^ 8'hA5, ~v};
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_ie(input logic v);
        if (v) ie_set = 1'b1; else ie_clr = 1'b1;
        step();
        ie_set = 1'b0;
        ie_clr = 1'b0;
    endtask

    task automatic do_swi(input logic [7:0] v, input logic [15:0] pc);
        insn_done = 1'b1; swi_req = 1'b1; swi_vec = v; pc_in = pc;
        step();
        insn_done = 1'b0; swi_req = 1'b0;
        chk("R3 no load one cycle after boundary", 32'(pc_load), 32'd0);
        step();
        chk("R3 load two cycles after boundary", 32'(pc_load), 32'd1);
        chk("R7 software vector target", 32'(pc_out), 32'(tgt(v)));
        chk("R9 ie cleared on entry", 32'(ie), 32'd0);
        step();
    endtask

    task automatic do_nmi(input logic [15:0] pc);
        nmi_req = 1'b1;
        step();
        nmi_req = 1'b0;
        step();
        insn_done = 1'b1; pc_in = pc;
        step();
        insn_done = 1'b0;
        step();
        chk("R4 nmi load", 32'(pc_load), 32'd1);
        chk("R4 nmi uses vector 2", 32'(pc_out), 32'(tgt(8'd2)));
        step();
    endtask

    task automatic do_int(input logic [7:0] v, input logic [15:0] pc);
        insn_done = 1'b1; int_req = 1'b1; pc_in = pc;
        step();
        chk("R6 ack one cycle after boundary", 32'(int_ack), 32'd1);
        insn_done = 1'b0; int_req = 1'b0; int_vec = v;
        step();
        chk("R6 ack lasts one cycle", 32'(int_ack), 32'd0);
        step();
        chk("R6 no load before fourth cycle", 32'(pc_load), 32'd0);
        step();
        chk("R6 load four cycles after boundary", 32'(pc_load), 32'd1);
        chk("R6 external vector target", 32'(pc_out), 32'(tgt(v)));
        int_vec = '0;
        step();
    endtask

    task automatic do_iret(input logic [15:0] exp_pc, input logic exp_ie);
        insn_done = 1'b1; iret_req = 1'b1;
        step();
        insn_done = 1'b0; iret_req = 1'b0;
        chk("R10 return load", 32'(pc_load), 32'd1);
        chk("R10 return address", 32'(pc_out), 32'(exp_pc));
        step();
        chk("R9 ie restored", 32'(ie), 32'(exp_ie));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 pc_load in reset", 32'(pc_load), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pc_load after reset", 32'(pc_load), 32'd0);
        chk("R1 int_ack after reset", 32'(int_ack), 32'd0);
        chk("R1 ie after reset", 32'(ie), 32'd0);
        chk("R1 busy after reset", 32'(busy), 32'd0);
        chk("R1 overflow after reset", 32'(stk_ovf), 32'd0);
        chk("R1 underflow after reset", 32'(stk_unf), 32'd0);

        for (int i = 0; i < 256; i++) begin
            tbl_we = 1'b1; tbl_idx = 8'(i); tbl_data = tgt(8'(i));
            step();
        end
        tbl_we = 1'b0;

        // Table walk: each entry is an entry followed by a return
        for (int i = 0; i < NV; i++) begin
            set_ie(1'b1);
            unique case (VTAB[i][25:24])
                2'd0:    do_swi(VTAB[i][23:16], VTAB[i][15:0]);
                2'd1:    do_nmi(VTAB[i][15:0]);
                default: do_int(VTAB[i][23:16], VTAB[i][15:0]);
            endcase
            chk("R9 ie low in handler", 32'(ie), 32'd0);
            do_iret(VTAB[i][15:0], 1'b1);
        end

        // R13 enable flag control
        set_ie(1'b0);
        chk("R13 ie_clr", 32'(ie), 32'd0);
        set_ie(1'b1);
        chk("R13 ie_set", 32'(ie), 32'd1);

        // R2 no boundary, no action
        swi_req = 1'b1; swi_vec = 8'h11;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R2 busy without boundary", 32'(busy), 32'd0);
            chk("R2 load without boundary", 32'(pc_load), 32'd0);
        end
        swi_req = 1'b0;

        // R5 masked request ignored
        set_ie(1'b0);
        insn_done = 1'b1; int_req = 1'b1;
        step();
        insn_done = 1'b0;
        chk("R5 masked no ack", 32'(int_ack), 32'd0);
        chk("R5 masked not busy", 32'(busy), 32'd0);
        step();
        chk("R5 masked no load", 32'(pc_load), 32'd0);
        int_req = 1'b0;

        // R4 held-high nmi serviced once, with ie low
        nmi_req = 1'b1;
        step(); step();
        insn_done = 1'b1; pc_in = 16'h0700;
        step();
        insn_done = 1'b0;
        step();
        chk("R4 nmi with ie low", 32'(pc_out), 32'(tgt(8'd2)));
        step();
        do_iret(16'h0700, 1'b0);
        insn_done = 1'b1;
        step();
        insn_done = 1'b0;
        chk("R4 held nmi not retaken", 32'(busy), 32'd0);
        step();
        chk("R4 held nmi no load", 32'(pc_load), 32'd0);
        nmi_req = 1'b0;

        // R8 precedence
        set_ie(1'b1);
        nmi_req = 1'b1; step(); nmi_req = 1'b0; step();
        insn_done = 1'b1; swi_req = 1'b1; swi_vec = 8'h33; pc_in = 16'h0500; int_req = 1'b1;
        step();
        insn_done = 1'b0; swi_req = 1'b0;
        chk("R8 software beats maskable", 32'(int_ack), 32'd0);
        step();
        chk("R8 software beats nmi", 32'(pc_out), 32'(tgt(8'h33)));
        step();
        int_req = 1'b0;
        do_iret(16'h0500, 1'b1);
        insn_done = 1'b1; pc_in = 16'h0600; int_req = 1'b1;
        step();
        insn_done = 1'b0;
        chk("R8 nmi beats maskable", 32'(int_ack), 32'd0);
        step();
        chk("R8 pending nmi taken later", 32'(pc_out), 32'(tgt(8'd2)));
        step();
        int_req = 1'b0;
        do_iret(16'h0600, 1'b1);
        do_int(8'h77, 16'h0900);
        do_iret(16'h0900, 1'b1);

        // R11 overflow, R12 underflow
        set_ie(1'b0);
        for (int k = 0; k < 9; k++) begin
            do_swi(8'(k + 16), 16'h1000 + 16'(k));
            if (k == 7) chk("R11 full stack no overflow yet", 32'(stk_ovf), 32'd0);
        end
        chk("R11 overflow flagged", 32'(stk_ovf), 32'd1);
        for (int k = 7; k >= 0; k--) begin
            do_iret(16'h1000 + 16'(k), 1'b0);
        end
        insn_done = 1'b1; iret_req = 1'b1;
        step();
        insn_done = 1'b0; iret_req = 1'b0;
        chk("R12 empty return no load", 32'(pc_load), 32'd0);
        step();
        chk("R12 underflow flagged", 32'(stk_unf), 32'd1);
        chk("R11 overflow sticky", 32'(stk_ovf), 32'd1);
        step();
        chk("R12 underflow sticky", 32'(stk_unf), 32'd1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule